// File: doc/BRIEF.md
# GPIO Bank with Activity-Driven Output Selection

This block is a bank of general-purpose pins, configured through a small register port with per-bit write masks. Each pin has a direction bit. Each pin's driven value comes from one of two places, chosen per bit. The first is a manual output register. The second is one of four state registers. The radio's current activity picks which state register applies, live, from two flags: receive active and transmit active. The pins can then be set to one value while idle, others while receiving or transmitting, and another during full duplex, with no software action.

Pins are brought out as separate value, enable and input vectors, so the pad ring can build the tristate buffer. The input vector passes through a two-stage synchronizer into a read-only readback register. Readback shows the true pin level, including pins the bank itself drives. When a chip has several radios, the activity flags must come from the first radio only.

Top module: `gpio_atr_bank`

## Requirements
- R1: After reset, the mode, direction and manual output registers are zero (and the four state registers too). Every pin_oe bit and every pin_out bit is 0.
- R2: A write to address wr_addr changes only the bits where wr_mask is 1. Those bits take wr_data. All other bits keep their old contents, as seen on the read port in the next cycle.
- R3: pin_oe bit n equals direction register (address 1) bit n, where 1 means output. A masked write to address 1 shows on pin_oe right after the write edge.
- R4: For a pin whose mode bit (address 0) is 0, pin_out takes the manual output register (address 2) one clock edge after that register is written.
- R5: For a pin whose mode bit is 1, pin_out takes the state register chosen by {tx_active, rx_active}. The choices are: 00 selects idle (address 3), 01 selects receive (address 4), 10 selects transmit (address 5), 11 selects full duplex (address 6).
- R6: A change on rx_active or tx_active shows on pin_out at the first clock edge after the change.
- R7: Readback (address 7) returns pin_in after two clock edges. A value applied before edge k is visible after edge k+1 and not after edge k alone.
- R8: Writes to address 7 have no effect: readback keeps following the pins.
- R9: Mode bits apply per pin. In one bank, manual and automatic pins mix in the same cycle, each taking its own source.
- R10: Pins driven as outputs and looped back by the pad appear in readback with their driven value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write word address |
| wr_data | input | WIDTH | Write value |
| wr_mask | input | WIDTH | Per-bit write enable |
| rd_addr | input | 3 | Read word address |
| rd_data | output | WIDTH | Read value (combinational) |
| rx_active | input | 1 | Radio receive activity flag |
| tx_active | input | 1 | Radio transmit activity flag |
| pin_in | input | WIDTH | Level present on each pad |
| pin_out | output | WIDTH | Registered value to drive on each pad |
| pin_oe | output | WIDTH | Pad output enable, 1 drives |

## Verification
The hardest case to reach from the ports is a mixed bank: some pins manual and others automatic, while the activity flags change under it. There, a mistake in the per-bit selection or a stale state register shows only on a few bits. The bench loads the four state registers with distinct patterns and sets a split mode mask. It then steps the flags through all four codes, checking pin_out one edge after each step. The synchronizer latency is probed by changing the pad inputs and reading readback after one edge and then after two.

// File: rtl/gpio_atr_bank.sv
module gpio_atr_bank #(
  parameter int WIDTH = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] wr_mask,
  input  logic [2:0]       rd_addr,
  output logic [WIDTH-1:0] rd_data,
  input  logic             rx_active,
  input  logic             tx_active,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);

  localparam logic [2:0] A_MODE = 3'd0;
  localparam logic [2:0] A_DIR  = 3'd1;
  localparam logic [2:0] A_MAN  = 3'd2;
  localparam logic [2:0] A_IDLE = 3'd3;
  localparam logic [2:0] A_RXO  = 3'd4;
  localparam logic [2:0] A_TXO  = 3'd5;
  localparam logic [2:0] A_DUP  = 3'd6;
  localparam logic [2:0] A_RDBK = 3'd7;

  if (WIDTH < 1 || WIDTH > 32) begin : g_width_check
    initial $fatal(1, "gpio_atr_bank: WIDTH must be 1..32");
  end

  logic [WIDTH-1:0] ctrl_q, dir_q, out_q;
  logic [WIDTH-1:0] st_idle_q, st_rx_q, st_tx_q, st_dup_q;
  logic [WIDTH-1:0] sync1_q, sync2_q;
  logic [WIDTH-1:0] st_sel, drive_nxt;

  function automatic logic [WIDTH-1:0] merge(input logic [WIDTH-1:0] old_v,
                                             input logic [WIDTH-1:0] new_v,
                                             input logic [WIDTH-1:0] m);
    return (old_v & ~m) | (new_v & m);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      dir_q     <= '0;
      out_q     <= '0;
      st_idle_q <= '0;
      st_rx_q   <= '0;
      st_tx_q   <= '0;
      st_dup_q  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_MODE: ctrl_q    <= merge(ctrl_q,    wr_data, wr_mask);
        A_DIR:  dir_q     <= merge(dir_q,     wr_data, wr_mask);
        A_MAN:  out_q     <= merge(out_q,     wr_data, wr_mask);
        A_IDLE: st_idle_q <= merge(st_idle_q, wr_data, wr_mask);
        A_RXO:  st_rx_q   <= merge(st_rx_q,   wr_data, wr_mask);
        A_TXO:  st_tx_q   <= merge(st_tx_q,   wr_data, wr_mask);
        A_DUP:  st_dup_q  <= merge(st_dup_q,  wr_data, wr_mask);
        default: ;
      endcase
    end
  end

  always_comb begin
    case ({tx_active, rx_active})
      2'b00:   st_sel = st_idle_q;
      2'b01:   st_sel = st_rx_q;
      2'b10:   st_sel = st_tx_q;
      default: st_sel = st_dup_q;
    endcase
  end

  assign drive_nxt = (ctrl_q & st_sel) | (~ctrl_q & out_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_out <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      pin_out <= drive_nxt;
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  assign pin_oe = dir_q;

  always_comb begin
    case (rd_addr)
      A_MODE:  rd_data = ctrl_q;
      A_DIR:   rd_data = dir_q;
      A_MAN:   rd_data = out_q;
      A_IDLE:  rd_data = st_idle_q;
      A_RXO:   rd_data = st_rx_q;
      A_TXO:   rd_data = st_tx_q;
      A_DUP:   rd_data = st_dup_q;
      A_RDBK:  rd_data = sync2_q;
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/gpio_atr_bank_chk.sv
module gpio_atr_bank_chk #(
  parameter int WIDTH = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic [WIDTH-1:0] wr_data,
  input logic [WIDTH-1:0] wr_mask,
  input logic             rx_active,
  input logic             tx_active,
  input logic [WIDTH-1:0] pin_in,
  input logic [WIDTH-1:0] pin_out,
  input logic [WIDTH-1:0] pin_oe,
  input logic [WIDTH-1:0] ctrl_q,
  input logic [WIDTH-1:0] out_q,
  input logic [WIDTH-1:0] st_dup_q,
  input logic [WIDTH-1:0] sync2_q
);

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_out == '0 && pin_oe == '0));

  // R2, R3
  a_r3_dir_masked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd1) |=>
      pin_oe == (($past(pin_oe) & ~$past(wr_mask)) | ($past(wr_data) & $past(wr_mask))));

  a_r4_manual_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q == '0) |=> pin_out == $past(out_q));

  a_r5_duplex_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q == '1 && rx_active && tx_active) |=> pin_out == $past(st_dup_q));

  a_r7_two_stage_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> sync2_q == $past(pin_in, 2));

endmodule

bind gpio_atr_bank gpio_atr_bank_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .wr_mask(wr_mask), .rx_active(rx_active),
  .tx_active(tx_active), .pin_in(pin_in), .pin_out(pin_out),
  .pin_oe(pin_oe), .ctrl_q(ctrl_q), .out_q(out_q),
  .st_dup_q(st_dup_q), .sync2_q(sync2_q)
);

// File: tb/gpio_atr_bank_tb_top.sv
module gpio_atr_bank_tb_top;
  localparam int W = 11;
  localparam int CLK_PERIOD = 10;
  localparam logic [W-1:0] ALL = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0, wr_mask = '0;
  logic [2:0] rd_addr = '0;
  logic [W-1:0] rd_data;
  logic rx_active = 1'b0, tx_active = 1'b0;
  logic [W-1:0] ext_in = '0;
  logic [W-1:0] pin_in, pin_out, pin_oe;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext_in);

  gpio_atr_bank #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_mask(wr_mask), .rd_addr(rd_addr),
    .rd_data(rd_data), .rx_active(rx_active), .tx_active(tx_active),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d, input logic [W-1:0] m);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_mask = m;
    @(negedge clk);
    wr_en = 1'b0; wr_mask = '0;
  endtask

  task automatic rd_check(input string req, input logic [2:0] a, input logic [W-1:0] exp);
    rd_addr = a;
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic t_reset;
    check("R1 oe", pin_oe, '0);
    check("R1 out", pin_out, '0);
    rd_check("R1 mode", 3'd0, '0);
    rd_check("R1 dir", 3'd1, '0);
    rd_check("R1 man", 3'd2, '0);
  endtask

  task automatic t_mask;
    wr(3'd0, ALL, 11'h00F);
    wr(3'd0, '0, 11'h003);
    rd_check("R2 mode masked", 3'd0, 11'h00C);
    wr(3'd3, 11'h7F0, 11'h0FF);
    rd_check("R2 idle masked", 3'd3, 11'h0F0);
    wr(3'd1, 11'h555, 11'h0F0);
    check("R3 oe masked", pin_oe, 11'h050);
    wr(3'd1, ALL, ALL);
    check("R3 oe all", pin_oe, ALL);
    wr(3'd0, '0, ALL);
    wr(3'd3, '0, ALL);
  endtask

  task automatic t_manual;
    wr(3'd2, 11'h5A5, ALL);
    @(negedge clk);
    check("R4 manual", pin_out, 11'h5A5);
    wr(3'd2, 11'h000, 11'h00F);
    @(negedge clk);
    check("R4 manual masked", pin_out, 11'h5A0);
  endtask

  task automatic t_atr;
    logic [W-1:0] pat [4];
    pat[0] = 11'h001; pat[1] = 11'h0C2; pat[2] = 11'h304; pat[3] = 11'h7F8;
    for (int i = 0; i < 4; i++) wr(3'(3 + i), pat[i], ALL);
    wr(3'd0, ALL, ALL);
    for (int s = 0; s < 4; s++) begin
      rx_active = s[0]; tx_active = s[1];
      @(negedge clk);
      check($sformatf("R5 state %0d", s), pin_out, pat[s]);
    end
    @(negedge clk);
    rx_active = 1'b1; tx_active = 1'b0;
    check("R6 before edge", pin_out, pat[3]);
    @(negedge clk);
    check("R6 after edge", pin_out, pat[1]);
  endtask

  task automatic t_mix;
    wr(3'd0, 11'h0F0, ALL);
    wr(3'd2, 11'h70F, ALL);
    rx_active = 1'b0; tx_active = 1'b1;
    @(negedge clk);
    check("R9 mix tx", pin_out, (11'h304 & 11'h0F0) | (11'h70F & ~11'h0F0));
    rx_active = 1'b1;
    @(negedge clk);
    check("R9 mix dup", pin_out, (11'h7F8 & 11'h0F0) | (11'h70F & ~11'h0F0));
    rx_active = 1'b0; tx_active = 1'b0;
  endtask

  task automatic t_readback;
    wr(3'd1, '0, ALL);
    ext_in = 11'h2B6;
    repeat (3) @(negedge clk);
    rd_check("R7 settled", 3'd7, 11'h2B6);
    ext_in = 11'h149;
    @(negedge clk);
    rd_check("R7 one edge", 3'd7, 11'h2B6);
    @(negedge clk);
    rd_check("R7 two edges", 3'd7, 11'h149);
    wr(3'd7, '0, ALL);
    rd_check("R8 write ignored", 3'd7, 11'h149);
    @(negedge clk);
    rd_check("R8 still pins", 3'd7, 11'h149);
  endtask

  task automatic t_loop;
    wr(3'd0, '0, ALL);
    wr(3'd2, 11'h00A, ALL);
    wr(3'd1, 11'h00F, ALL);
    ext_in = 11'h7F5;
    repeat (4) @(negedge clk);
    rd_check("R10 loopback", 3'd7, 11'h7FA);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_manual();
    t_atr();
    t_mix();
    t_readback();
    t_loop();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule